// File: doc/BRIEF.md
# Color Palette RAM Loader

This block is a host-loaded color lookup table of the kind found at the back of a video pipeline. The host steers it through one narrow write path whose two select bits choose one of three targets. The first is an index register. The second is a data port for the 256 bitmap colors. The third is a data port for four extra overlay colors, which are stored after the bitmap colors at entries 256 to 259. Each color arrives as three separate byte writes. The first two bytes wait in a staging register. The third byte completes the triple, and the whole 24-bit color is written into the table in a single cycle.

Internally the block keeps a pointer. The upper bits of the pointer give the entry and the two low bits give the component. The pointer never stops on the fourth component slot, so successive triples fill successive entries without further index writes. At the end of each port's range the pointer wraps back to zero. When a commit changes a stored color, the block raises a refresh request that stays set until it is acknowledged. The pixel pipeline reads colors through its own registered lookup port, which works independently of host writes.

Top module: `clut_loader`

## Requirements
- R1: The write select is decoded as follows: 0 is the index register, 1 is the bitmap data port, 2 is the overlay data port, and 3 is ignored, so the pointer and the palette do not change. A write to the index register loads the pointer with the written value times four, so the next data byte is component 0 of that entry. An index write in the middle of an entry restarts at component 0.
- R2: Each accepted data byte goes into the component slot given by the two low pointer bits, and then the pointer advances. The third byte commits the entry, and the pointer then moves to component 0 of the next entry.
- R3: The pointer never stops on component slot 3, so consecutive byte triples fill consecutive entries.
- R4: On the bitmap port, the triple that commits entry 255 returns the pointer to 0, so the next triple commits entry 0.
- R5: The overlay port accepts a byte only while the pointer is below 16. Its triples commit entries 256 to 259, and after entry 259 the pointer returns to 0. An overlay byte written while the pointer is 16 or higher changes nothing: not the pointer, not the palette, and not the staging register.
- R6: A committed color places the first byte in bits 23:16, the second byte in bits 15:8 and the third byte in bits 7:0.
- R7: A commit whose value differs from the entry's previous contents sets the refresh request two clock edges after the commit edge. A commit of an identical value leaves the request unchanged.
- R8: The request holds until an acknowledge is sampled, and is clear after that edge. If a set and an acknowledge fall on the same edge, the set wins.
- R9: The lookup output shows the color at the index sampled on the previous edge. An index of 260 or above returns zero. A commit to the looked-up entry on that same edge returns the old color.
- R10: Reset clears the pointer, the staging bytes and the refresh request. Palette contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Target select: 0 index, 1 bitmap data, 2 overlay data, 3 none |
| wr_data | input | 8 | Host write byte |
| refresh_ack | input | 1 | One-cycle acknowledge that clears the refresh request |
| lookup_idx | input | 9 | Palette index for the pixel pipeline |
| lookup_color | output | 24 | Registered color, one cycle after the index |
| refresh_req | output | 1 | Set when a commit changed a stored color |

## Verification
The bench uses the default build: 256 bitmap entries, 4 overlay entries and 8-bit components. At this size a complete fill of the bitmap table and its wrap back to entry 0 take fewer than 800 host writes, and the overlay wrap takes only fifteen writes. Every lookup index, including the out-of-range codes 260 to 263, can be swept in one pass. Because the overlay window is small, both the pointer values the overlay port refuses and a read that collides with a commit on the same edge can be produced directly.

// File: rtl/clut_pkg.sv
package clut_pkg;

  typedef enum logic [1:0] {
    SEL_INDEX = 2'd0,
    SEL_MAIN  = 2'd1,
    SEL_OVL   = 2'd2,
    SEL_NONE  = 2'd3
  } port_sel_e;

endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int NUM_MAIN = 256,
  parameter int NUM_OVL  = 4,
  parameter int COMP_W   = 8,
  parameter int IDX_W    = 9,
  parameter int PTR_W    = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [COMP_W-1:0]   wr_data,
  output logic [PTR_W-1:0]    ptr,
  output logic                cm_we,
  output logic [IDX_W-1:0]    cm_addr,
  output logic [3*COMP_W-1:0] cm_data
);

  localparam logic [PTR_W:0] MAIN_LIM = (PTR_W+1)'(NUM_MAIN * 4);
  localparam logic [PTR_W:0] OVL_LIM  = (PTR_W+1)'(NUM_OVL * 4);

  logic [PTR_W-1:0]  ptr_q;
  logic [COMP_W-1:0] stage0_q, stage1_q;
  logic              take_main, take_ovl, take_any, done;
  logic [PTR_W:0]    step1, step2, lim;
  logic [PTR_W-1:0]  ptr_nxt;

  always_comb begin
    take_main = !rst && wr_en && (port_sel_e'(wr_sel) == SEL_MAIN);
    take_ovl  = !rst && wr_en && (port_sel_e'(wr_sel) == SEL_OVL) &&
                ({1'b0, ptr_q} < OVL_LIM);
    take_any  = take_main || take_ovl;
    lim       = take_ovl ? OVL_LIM : MAIN_LIM;
    step1     = {1'b0, ptr_q} + 1'b1;
    done      = (step1[1:0] == 2'b11);
    step2     = done ? step1 + 1'b1 : step1;
    ptr_nxt   = (step2 >= lim) ? '0 : step2[PTR_W-1:0];
    cm_we     = take_any && done;
    cm_addr   = (take_ovl ? IDX_W'(NUM_MAIN) : '0) + IDX_W'(ptr_q[PTR_W-1:2]);
    cm_data   = {stage0_q, stage1_q, wr_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      stage0_q <= '0;
      stage1_q <= '0;
    end else if (wr_en && port_sel_e'(wr_sel) == SEL_INDEX) begin
      ptr_q <= PTR_W'({wr_data, 2'b00});
    end else if (take_any) begin
      if (ptr_q[1:0] == 2'd0) stage0_q <= wr_data;
      if (ptr_q[1:0] == 2'd1) stage1_q <= wr_data;
      ptr_q <= ptr_nxt;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/clut_ram.sv
module clut_ram #(
  parameter int DEPTH = 260,
  parameter int W     = 24,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  a_wdata,
  output logic [W-1:0]  a_old,
  input  logic [AW-1:0] b_addr,
  output logic [W-1:0]  b_rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_old <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/clut_change.sv
module clut_change #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         commit,
  input  logic [W-1:0] new_data,
  input  logic [W-1:0] old_data,
  input  logic         ack,
  output logic         req
);

  logic         pend_q, req_q;
  logic [W-1:0] new_q;
  logic         differs;

  always_comb differs = pend_q && (old_data != new_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      pend_q <= commit;
      req_q  <= differs || (req_q && !ack);
    end
    new_q <= new_data;
  end

  assign req = req_q;

endmodule

// File: rtl/clut_loader.sv
module clut_loader #(
  parameter int NUM_MAIN = 256,
  parameter int NUM_OVL  = 4,
  parameter int COMP_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [1:0]                   wr_sel,
  input  logic [COMP_W-1:0]            wr_data,
  input  logic                         refresh_ack,
  input  logic [$clog2(NUM_MAIN+NUM_OVL)-1:0] lookup_idx,
  output logic [3*COMP_W-1:0]          lookup_color,
  output logic                         refresh_req
);

  localparam int TOTAL = NUM_MAIN + NUM_OVL;
  localparam int IDX_W = $clog2(TOTAL);
  localparam int PTR_W = $clog2(NUM_MAIN * 4);
  localparam int CW    = 3 * COMP_W;

  logic [PTR_W-1:0] ptr;
  logic             commit;
  logic [IDX_W-1:0] cm_addr, rd_addr;
  logic [CW-1:0]    cm_data, old_data, rd_data;
  logic             oob, oob_q;

  clut_seq #(
    .NUM_MAIN(NUM_MAIN), .NUM_OVL(NUM_OVL), .COMP_W(COMP_W),
    .IDX_W(IDX_W), .PTR_W(PTR_W)
  ) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ptr(ptr), .cm_we(commit), .cm_addr(cm_addr), .cm_data(cm_data)
  );

  always_comb begin
    oob     = ({1'b0, lookup_idx} >= (IDX_W+1)'(TOTAL));
    rd_addr = oob ? '0 : lookup_idx;
  end

  clut_ram #(.DEPTH(TOTAL), .W(CW), .AW(IDX_W)) u_ram (
    .clk(clk), .a_we(commit), .a_addr(cm_addr), .a_wdata(cm_data),
    .a_old(old_data), .b_addr(rd_addr), .b_rdata(rd_data)
  );

  clut_change #(.W(CW)) u_chg (
    .clk(clk), .rst(rst), .commit(commit), .new_data(cm_data),
    .old_data(old_data), .ack(refresh_ack), .req(refresh_req)
  );

  always_ff @(posedge clk) begin
    if (rst) oob_q <= 1'b0;
    else     oob_q <= oob;
  end

  assign lookup_color = oob_q ? '0 : rd_data;

endmodule

// File: rtl/clut_loader_chk.sv
module clut_loader_chk #(
  parameter int PTR_W  = 10,
  parameter int COMP_W = 8,
  parameter int NUM_OVL = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [COMP_W-1:0] wr_data,
  input logic              refresh_ack,
  input logic              refresh_req,
  input logic [PTR_W-1:0]  ptr,
  input logic              commit
);

  localparam logic [PTR_W:0] OVL_LIM = (PTR_W+1)'(NUM_OVL * 4);

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (ptr == '0 && !refresh_req));

  a_r1_index_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0) |=> ptr == PTR_W'({$past(wr_data), 2'b00}));

  a_r1_none_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3) |=> $stable(ptr));

  a_r3_no_slot3: assert property (@(posedge clk) disable iff (rst)
    ptr[1:0] != 2'b11);

  a_r2_commit_next_entry: assert property (@(posedge clk) disable iff (rst)
    commit |=> ptr[1:0] == 2'b00);

  a_r5_ovl_gate_ptr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd2 && {1'b0, ptr} >= OVL_LIM) |=> $stable(ptr));

  a_r5_ovl_gate_commit: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd2 && {1'b0, ptr} >= OVL_LIM) |-> !commit);

  a_r7_req_source: assert property (@(posedge clk) disable iff (rst)
    $rose(refresh_req) |-> $past(commit, 2));

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (refresh_ack && !$past(commit)) |=> !refresh_req);

endmodule

bind clut_loader clut_loader_chk #(
  .PTR_W(PTR_W), .COMP_W(COMP_W), .NUM_OVL(NUM_OVL)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .refresh_ack(refresh_ack), .refresh_req(refresh_req), .ptr(ptr),
  .commit(commit)
);

// File: tb/test_clut_loader.sv
module test_clut_loader;

  localparam int CLK_PERIOD = 10;
  localparam int NMAIN = 256;
  localparam int NOVL  = 4;
  localparam int NTOT  = NMAIN + NOVL;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        refresh_ack = 1'b0;
  logic [8:0]  lookup_idx = 9'd0;
  logic [23:0] lookup_color;
  logic        refresh_req;

  clut_loader i_clut_loader (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .refresh_ack(refresh_ack), .lookup_idx(lookup_idx),
    .lookup_color(lookup_color), .refresh_req(refresh_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_req  = "R10";
  bit    started  = 0;

  // behavioural reference model
  int pal [NTOT];
  bit pv  [NTOT];
  int m_ptr = 0, m_s0 = 0, m_s1 = 0;
  bit m_flag = 0, m_fk = 1, pend = 0, pend_unk = 0;
  int e_col = 0;
  bit e_ck = 0;

  initial for (int i = 0; i < NTOT; i++) begin pal[i] = 0; pv[i] = 0; end

  always @(posedge clk) begin
    int lim, nv, ix;
    if (int'(lookup_idx) >= NTOT) begin e_col = 0; e_ck = 1; end
    else begin e_col = pal[lookup_idx]; e_ck = pv[lookup_idx]; end
    if (rst) begin
      m_ptr = 0; m_s0 = 0; m_s1 = 0; m_flag = 0; m_fk = 1; pend = 0; pend_unk = 0;
    end else begin
      if (pend_unk) m_fk = 0;
      else if (pend) begin m_flag = 1; m_fk = 1; end
      else if (refresh_ack) begin m_flag = 0; m_fk = 1; end
      pend = 0; pend_unk = 0;
      if (wr_en) begin
        if (wr_sel == 2'd0) m_ptr = int'(wr_data) * 4;
        else if (wr_sel == 2'd1 || (wr_sel == 2'd2 && m_ptr < NOVL * 4)) begin
          lim = (wr_sel == 2'd1) ? NMAIN * 4 : NOVL * 4;
          case (m_ptr % 4)
            0: m_s0 = int'(wr_data);
            1: m_s1 = int'(wr_data);
            default: begin
              ix = ((wr_sel == 2'd2) ? NMAIN : 0) + m_ptr / 4;
              nv = m_s0 * 65536 + m_s1 * 256 + int'(wr_data);
              if (pv[ix]) pend = (pal[ix] != nv); else pend_unk = 1;
              pal[ix] = nv; pv[ix] = 1;
            end
          endcase
          m_ptr++;
          if (m_ptr % 4 == 3) m_ptr++;
          if (m_ptr >= lim) m_ptr = 0;
        end
      end
    end
    started = 1;
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      if (e_ck)
        check(lookup_color == 24'(e_col), {cur_req, " lookup_color"}, int'(lookup_color), e_col);
      if (m_fk)
        check(refresh_req == m_flag, {cur_req, " refresh_req"}, int'(refresh_req), int'(m_flag));
    end
  end

  function automatic logic [7:0] pat(int e, int c);
    return 8'((e * 7 + c * 61 + 1) & 255);
  endfunction

  task automatic hw(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d; refresh_ack = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      wr_en = 1'b0; refresh_ack = 1'b0;
    end
  endtask

  task automatic do_ack();
    @(negedge clk);
    wr_en = 1'b0; refresh_ack = 1'b1;
    @(negedge clk);
    refresh_ack = 1'b0;
  endtask

  task automatic expect_color(int idx, int exp, string tag);
    @(negedge clk);
    wr_en = 1'b0; refresh_ack = 1'b0; lookup_idx = 9'(idx);
    @(negedge clk);
    check(lookup_color == 24'(exp), tag, int'(lookup_color), exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    cur_req = "R10 reset";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    check(refresh_req == 1'b0, "R10 request clear after reset", int'(refresh_req), 0);

    hw(1, 8'h11); hw(1, 8'h22); hw(1, 8'h33); idle(1);
    expect_color(0, 'h112233, "R10 pointer starts at entry 0");
    expect_color(0, 'h112233, "R6 byte packing");

    cur_req = "R2 main fill";
    hw(0, 8'd0);
    for (int e = 0; e < NMAIN; e++)
      for (int c = 0; c < 3; c++) hw(1, pat(e, c));
    cur_req = "R4 main wrap";
    hw(1, 8'hA1); hw(1, 8'hB2); hw(1, 8'hC3); idle(1);
    expect_color(0, 'hA1B2C3, "R4 wrap to entry 0");
    expect_color(255, {pat(255, 0), pat(255, 1), pat(255, 2)}, "R2 last entry");

    cur_req = "R5 overlay fill";
    hw(0, 8'd0);
    for (int e = 0; e < NOVL; e++)
      for (int c = 0; c < 3; c++) hw(2, pat(e + 100, c));
    hw(2, 8'h5A); hw(2, 8'h6B); hw(2, 8'h7C); idle(1);
    expect_color(259, {pat(103, 0), pat(103, 1), pat(103, 2)}, "R5 overlay entry 259");
    expect_color(256, 'h5A6B7C, "R5 overlay wrap to 256");
    do_ack(); idle(2);

    cur_req = "R9 lookup scan";
    for (int i = 0; i < 264; i++) begin
      @(negedge clk); lookup_idx = 9'(i);
    end
    idle(2);
    expect_color(261, 0, "R9 out-of-range index");

    cur_req = "R7 identical commit";
    hw(0, 8'd10);
    for (int c = 0; c < 3; c++) hw(1, pat(10, c));
    idle(4);
    check(refresh_req == 1'b0, "R7 identical commit no request", int'(refresh_req), 0);

    cur_req = "R7 changed commit";
    hw(0, 8'd10); hw(1, 8'd1); hw(1, 8'd2); hw(1, 8'd3);
    idle(1);
    check(refresh_req == 1'b0, "R7 request not yet set", int'(refresh_req), 0);
    idle(1);
    check(refresh_req == 1'b1, "R7 request set two edges after commit", int'(refresh_req), 1);

    cur_req = "R8 acknowledge";
    do_ack();
    check(refresh_req == 1'b0, "R8 ack clears", int'(refresh_req), 0);
    hw(0, 8'd11); hw(1, 8'h09); hw(1, 8'h09); hw(1, 8'h09);
    @(negedge clk); wr_en = 1'b0; refresh_ack = 1'b1;
    @(negedge clk); refresh_ack = 1'b0;
    check(refresh_req == 1'b1, "R8 set wins over ack", int'(refresh_req), 1);
    do_ack();

    cur_req = "R5 overlay gate";
    hw(0, 8'd4);
    hw(2, 8'hEE); hw(2, 8'hEE); hw(2, 8'hEE);
    hw(1, 8'h44); hw(1, 8'h55); hw(1, 8'h66); idle(1);
    expect_color(4, 'h445566, "R5 rejected overlay bytes");
    expect_color(256, 'h5A6B7C, "R5 overlay entry untouched");

    cur_req = "R1 select decode";
    hw(0, 8'd20); hw(1, 8'h01); hw(0, 8'd20); hw(3, 8'h99);
    hw(1, 8'hAA); hw(1, 8'hBB); hw(1, 8'hCC); idle(1);
    expect_color(20, 'hAABBCC, "R1 index restart and select 3 ignored");

    cur_req = "R3 slot skip";
    hw(0, 8'd30);
    hw(1, 8'h31); hw(1, 8'h32); hw(1, 8'h33);
    hw(1, 8'h41); hw(1, 8'h42); hw(1, 8'h43); idle(1);
    expect_color(30, 'h313233, "R3 first entry");
    expect_color(31, 'h414243, "R3 next entry");

    cur_req = "R9 read during commit";
    @(negedge clk); lookup_idx = 9'd40;
    hw(0, 8'd40); hw(1, 8'hDE); hw(1, 8'hAD); hw(1, 8'hBE);
    idle(3);
    check(lookup_color == 24'hDEADBE, "R9 new value after commit", int'(lookup_color), 'hDEADBE);
    do_ack(); idle(2);
    summary();
  end

endmodule